// File: doc/BRIEF.md
# Neighbour-Channel 3x3 Morphology Filter

This block is the consumer end of a pixel pipeline that carries a 3x3 neighbourhood over nine separate streams instead of through line buffers. Each of the nine input channels is tied to one window position: the value that arrives on a channel for an output pixel is the frame pixel at that offset from it. The block walks the frame in raster order. For each position it pops only the channels whose neighbour lies inside the frame. It then reduces the collected values to their minimum (erosion) or maximum (dilation) and presents one result on a valid/ready output.

Channels deliver their values on independent valid/ready handshakes, in any order and with any gaps. The block keeps one value per channel for the current pixel and refuses further values on that channel until the pixel is emitted. A slow channel therefore stalls only its own stream, and the output waits for it. The frame size and pixel width are parameters. The erosion/dilation selection is taken once per frame and holds for all of that frame's pixels.

Top module: `nbr_morph_filter`

## Requirements
- R1: With erosion selected (mode input 0), each output equals the minimum of the values taken from the channels whose neighbour lies inside the frame.
- R2: With dilation selected (mode input 1), each output equals the maximum of those same in-frame values.
- R3: Channel index k (0..8) carries the neighbour at row offset k/3-1 and column offset k%3-1, so index 0 is upper-left, 4 is the pixel itself and 8 is lower-right. At the start of each pixel the ready vector equals exactly the set of in-frame neighbours: 4 channels at a corner, 6 on an edge and 9 inside.
- R4: Outputs appear one per position in raster order, with columns running fastest. After the last pixel of the frame the position returns to row 0, column 0 for the next frame.
- R5: A channel whose neighbour falls outside the frame is never made ready, and values offered on it have no effect on the output.
- R6: No output is produced until every required channel has delivered a value, and each channel accepts at most one value per pixel.
- R7: While the output is valid and not accepted, its valid and data stay unchanged.
- R8: The mode input is taken when the first pixel of a frame is emitted. Changes to it later in the frame have no effect until the next frame.
- R9: After reset the output is not valid, and the ready vector shows the corner set for position (0,0): indices 4, 5, 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_dilate_i | input | 1 | 0 selects erosion (min), 1 selects dilation (max) |
| ch_valid_i | input | 9 | Valid for each neighbour channel, bit k is channel k |
| ch_data_i | input | 9*DW | Channel values, channel k in bits [k*DW +: DW] |
| ch_ready_o | output | 9 | Ready for each neighbour channel |
| out_valid_o | output | 1 | Filtered pixel available |
| out_data_o | output | DW | Filtered pixel value |
| out_ready_i | input | 1 | Downstream accepts the filtered pixel |

## Verification
The bench targets the four corners and the edges. There, a design with a wrong neighbour mask would either hang waiting for a channel that never comes, or take junk values that the bench deliberately offers on out-of-frame channels and corrupt the min or max. Single extreme pixels placed at the corners show whether the reduction and the window offsets line up. A withheld channel on the first pixel shows whether a design emits early. Mid-frame mode flips and random output back-pressure expose a design that samples the mode per pixel or lets a stalled output change.

// File: rtl/nbr_pkg.sv
// Shared constants and helpers for the neighbour-channel morphology filter.
// Assumes a fixed 3x3 window; channel k sits at row k/3-1, column k%3-1.
package nbr_pkg;
    localparam int NBR_SIDE = 3;
    localparam int NBR_NCH  = NBR_SIDE * NBR_SIDE;

    // Row offset (-1, 0, +1) of channel k within the window.
    function automatic int nbr_row_off(input int k);
        return (k / NBR_SIDE) - 1;
    endfunction

    // Column offset (-1, 0, +1) of channel k within the window.
    function automatic int nbr_col_off(input int k);
        return (k % NBR_SIDE) - 1;
    endfunction
endpackage

// File: rtl/nbr_pos_tracker.sv
// Raster position counter and in-frame neighbour mask.
// Advances one position per emitted pixel and wraps to (0,0) after the last one.
// Assumes FRAME_W >= 2 and FRAME_H >= 2.
module nbr_pos_tracker
    import nbr_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int FRAME_H = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance_i,
    output logic [NBR_NCH-1:0] need_o,
    output logic               first_o,
    output logic               last_o
);
    localparam int COL_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int ROW_W = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(FRAME_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(FRAME_H - 1);

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic at_top, at_bot, at_lft, at_rgt;

    // Step the raster position on each emitted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (advance_i) begin
            if (col_q == COL_LAST) begin
                col_q <= '0;
                row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // Frame edge flags for the current position.
    always_comb begin
        at_top = (row_q == '0);
        at_bot = (row_q == ROW_LAST);
        at_lft = (col_q == '0);
        at_rgt = (col_q == COL_LAST);
    end

    assign first_o = at_top & at_lft;
    assign last_o  = at_bot & at_rgt;

    // One mask bit per channel: set when that neighbour lies inside the frame.
    for (genvar k = 0; k < NBR_NCH; k++) begin : g_need
        localparam int DR = nbr_row_off(k);
        localparam int DC = nbr_col_off(k);
        logic row_ok, col_ok;
        always_comb begin
            row_ok = (DR < 0) ? !at_top : ((DR > 0) ? !at_bot : 1'b1);
            col_ok = (DC < 0) ? !at_lft : ((DC > 0) ? !at_rgt : 1'b1);
        end
        assign need_o[k] = row_ok & col_ok;
    end

    // R4: position never leaves the frame.
    p_pos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(col_q) < FRAME_W) && (32'(row_q) < FRAME_H));

    // R4: the last pixel is followed by (0,0).
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && last_o) |=> first_o);

    // R3: only corner, edge or interior window sizes occur.
    p_need_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(need_o) == 4) || ($countones(need_o) == 6) ||
        ($countones(need_o) == 9));
endmodule

// File: rtl/nbr_chan_slot.sv
// Single-entry holding slot for one neighbour channel.
// Accepts one value per pixel when that channel is required, then holds it
// until the pixel is emitted (clear_i). Assumes need_i is stable between clears.
module nbr_chan_slot #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          need_i,
    input  logic          clear_i,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    output logic          ready_o,
    output logic          got_o,
    output logic [DW-1:0] data_o
);
    logic got_q;
    logic [DW-1:0] data_q;

    assign ready_o = need_i & ~got_q;

    // Track whether this pixel's value has arrived and keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_q  <= 1'b0;
            data_q <= '0;
        end else if (clear_i) begin
            got_q <= 1'b0;
        end else if (valid_i && ready_o) begin
            got_q  <= 1'b1;
            data_q <= data_i;
        end
    end

    assign got_o  = got_q;
    assign data_o = data_q;
endmodule

// File: rtl/nbr_minmax.sv
// Masked min/max reduction over the nine held channel values.
// Masked-out lanes take the identity: all-ones for min, zero for max.
module nbr_minmax
    import nbr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [NBR_NCH*DW-1:0] vals_i,
    input  logic [NBR_NCH-1:0]    mask_i,
    input  logic                  dilate_i,
    output logic [DW-1:0]         res_o
);
    logic [DW-1:0] acc;
    logic [DW-1:0] lane;

    // Linear scan keeping the running extreme of the included lanes.
    always_comb begin
        acc  = dilate_i ? '0 : '1;
        lane = '0;
        for (int k = 0; k < NBR_NCH; k++) begin
            lane = vals_i[k*DW +: DW];
            if (mask_i[k]) begin
                if (dilate_i) begin
                    if (lane > acc) acc = lane;
                end else begin
                    if (lane < acc) acc = lane;
                end
            end
        end
    end

    assign res_o = acc;
endmodule

// File: rtl/nbr_morph_filter.sv
// 3x3 erosion/dilation over nine position-labelled input channels.
// Visits pixels in raster order, pops only in-frame neighbour channels,
// reduces them and emits one pixel on a valid/ready output register.
// Assumes FRAME_W >= 2 and FRAME_H >= 2.
module nbr_morph_filter
    import nbr_pkg::*;
#(
    parameter int DW      = 8,
    parameter int FRAME_W = 8,
    parameter int FRAME_H = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_dilate_i,
    input  logic [NBR_NCH-1:0]    ch_valid_i,
    input  logic [NBR_NCH*DW-1:0] ch_data_i,
    output logic [NBR_NCH-1:0]    ch_ready_o,
    output logic                  out_valid_o,
    output logic [DW-1:0]         out_data_o,
    input  logic                  out_ready_i
);
    logic [NBR_NCH-1:0]    need;
    logic [NBR_NCH-1:0]    got;
    logic [NBR_NCH*DW-1:0] held;
    logic                  first_px, last_px;
    logic                  all_got, load;
    logic                  frame_dilate_q, eff_dilate;
    logic [DW-1:0]         red_res;

    assign all_got    = &(got | ~need);
    assign load       = all_got & (~out_valid_o | out_ready_i);
    assign eff_dilate = first_px ? mode_dilate_i : frame_dilate_q;

    nbr_pos_tracker #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance_i(load),
        .need_o   (need),
        .first_o  (first_px),
        .last_o   (last_px)
    );

    for (genvar k = 0; k < NBR_NCH; k++) begin : g_slot
        nbr_chan_slot #(.DW(DW)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .need_i (need[k]),
            .clear_i(load),
            .valid_i(ch_valid_i[k]),
            .data_i (ch_data_i[k*DW +: DW]),
            .ready_o(ch_ready_o[k]),
            .got_o  (got[k]),
            .data_o (held[k*DW +: DW])
        );
    end

    nbr_minmax #(.DW(DW)) u_red (
        .vals_i  (held),
        .mask_i  (need),
        .dilate_i(eff_dilate),
        .res_o   (red_res)
    );

    // Latch the frame's mode when its first pixel is emitted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_dilate_q <= 1'b0;
        end else if (load && first_px) begin
            frame_dilate_q <= mode_dilate_i;
        end
    end

    // Output register with valid/ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else if (load) begin
            out_valid_o <= 1'b1;
            out_data_o  <= red_res;
        end else if (out_ready_i) begin
            out_valid_o <= 1'b0;
        end
    end

    // R7: a stalled output holds its value.
    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R6: after an emit every slot re-arms on exactly the new pixel's neighbours.
    p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ch_ready_o == need));

    // R5: never ready on a channel outside the frame.
    p_no_outside_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ready_o & ~need) == '0);
endmodule

// File: tb/nbr_morph_filter_tb.sv
// Self-checking bench: directed corner frames plus seeded random frames,
// random channel gaps, junk on out-of-frame channels and output back-pressure.
module nbr_morph_filter_tb;
    localparam int DW = 8;
    localparam int FW = 5;
    localparam int FH = 4;
    localparam int NPX = FW * FH;
    localparam int NFRAMES = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_dilate = 1'b0;
    logic [8:0]    ch_valid = '0;
    logic [9*DW-1:0] ch_data = '0;
    logic [8:0]    ch_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ready = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    logic [DW-1:0] img [0:FH-1][0:FW-1];
    logic [DW-1:0] exp_q [$];
    bit            frame_mode [0:NFRAMES-1];

    always #10 clk = ~clk;

    nbr_morph_filter #(.DW(DW), .FRAME_W(FW), .FRAME_H(FH)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_dilate_i(mode_dilate),
        .ch_valid_i   (ch_valid),
        .ch_data_i    (ch_data),
        .ch_ready_o   (ch_ready),
        .out_valid_o  (out_valid),
        .out_data_o   (out_data),
        .out_ready_i  (out_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // In-frame neighbour set for (r,c) per R3.
    function automatic logic [8:0] need_of(input int r, input int c);
        logic [8:0] m = '0;
        for (int k = 0; k < 9; k++) begin
            int rr = r + k / 3 - 1;
            int cc = c + k % 3 - 1;
            m[k] = (rr >= 0) && (rr < FH) && (cc >= 0) && (cc < FW);
        end
        return m;
    endfunction

    // Reference min (R1) or max (R2) over in-frame neighbours.
    function automatic logic [DW-1:0] ref_px(input int r, input int c, input bit dil);
        logic [DW-1:0] a = dil ? 8'h00 : 8'hFF;
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                if (r + dr >= 0 && r + dr < FH && c + dc >= 0 && c + dc < FW) begin
                    if (dil && img[r+dr][c+dc] > a) a = img[r+dr][c+dc];
                    if (!dil && img[r+dr][c+dc] < a) a = img[r+dr][c+dc];
                end
        return a;
    endfunction

    function automatic logic [DW-1:0] nbr_val(input int r, input int c, input int k);
        return img[r + k / 3 - 1][c + k % 3 - 1];
    endfunction

    // Feed one pixel's channels with random gaps; junk on unneeded channels.
    task automatic drive_pixel(input int r, input int c, input bit holdoff);
        logic [8:0] pending = need_of(r, c);
        logic [8:0] vld, acc;
        bit seen_ready = 0;
        int cyc = 0;
        while (pending != 0) begin
            @(negedge clk);
            for (int k = 0; k < 9; k++) begin
                if (pending[k]) begin
                    vld[k] = ($urandom % 4) != 0;
                    ch_data[k*DW +: DW] = nbr_val(r, c, k);
                end else begin
                    vld[k] = ($urandom % 3) == 0;
                    ch_data[k*DW +: DW] = DW'($urandom);
                end
            end
            if (holdoff && cyc < 10) vld[8] = 1'b0;
            ch_valid = vld;
            #1;
            // R5: no channel outside the frame (or already served) is ready.
            check((ch_ready & ~pending) == 0, "R5 ready outside set", ch_ready, pending);
            if (!seen_ready && ch_ready != 0) begin
                seen_ready = 1;
                // R3: on re-arm the ready set equals the in-frame neighbours.
                check(ch_ready == pending, "R3 ready set", ch_ready, pending);
            end
            // R6: nothing emitted while a required channel is withheld.
            if (holdoff && cyc < 10) check(out_valid == 1'b0, "R6 early emit", out_valid, 0);
            acc = vld & ch_ready;
            @(posedge clk);
            pending &= ~acc;
            cyc++;
        end
    endtask

    task automatic fill_frame(input int f);
        for (int r = 0; r < FH; r++)
            for (int c = 0; c < FW; c++)
                case (f)
                    0: img[r][c] = 8'd77;
                    1: img[r][c] = ((r + c) % 2 == 0) ? 8'd0 : 8'd255;
                    2: img[r][c] = (r == 0 && c == 0) ? 8'd255 : 8'd10;
                    3: img[r][c] = (r == FH-1 && c == FW-1) ? 8'd0 : 8'd200;
                    4: img[r][c] = (r == 0 && c == FW-1) ? 8'd250 : 8'd20;
                    5: img[r][c] = (r == FH-1 && c == 0) ? 8'd1 : 8'd90;
                    default: img[r][c] = DW'($urandom);
                endcase
    endtask

    task automatic driver();
        for (int f = 0; f < NFRAMES; f++) begin
            case (f)
                0: frame_mode[f] = 0;
                1: frame_mode[f] = 1;
                2: frame_mode[f] = 1;
                3: frame_mode[f] = 0;
                4: frame_mode[f] = 1;
                5: frame_mode[f] = 0;
                default: frame_mode[f] = $urandom % 2;
            endcase
            fill_frame(f);
            for (int r = 0; r < FH; r++)
                for (int c = 0; c < FW; c++)
                    exp_q.push_back(ref_px(r, c, frame_mode[f]));
            mode_dilate = frame_mode[f];
            for (int p = 0; p < NPX; p++) begin
                drive_pixel(p / FW, p % FW, (f == 0) && (p == 0));
                // R8: flip the mode once the frame's first pixel has been emitted.
                if (p == 1) mode_dilate = ~frame_mode[f];
            end
        end
        @(negedge clk);
        ch_valid = '0;
    endtask

    task automatic consumer();
        bit stalled = 0;
        logic [DW-1:0] prev = '0;
        int got_n = 0;
        while (got_n < NFRAMES * NPX) begin
            @(negedge clk);
            out_ready = ($urandom % 3) != 0;
            #1;
            if (out_valid) begin
                if (stalled) check(out_data == prev, "R7 hold under stall", out_data, prev);
                if (out_ready) begin
                    logic [DW-1:0] e = exp_q.pop_front();
                    // R1/R2 value, R4 raster order and wrap, R8 per-frame mode.
                    check(out_data == e,
                          frame_mode[got_n / NPX] ? "R2 R4 R8 dilate pixel" : "R1 R4 R8 erode pixel",
                          out_data, e);
                    got_n++;
                end
            end
            stalled = out_valid && !out_ready;
            prev = out_data;
        end
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state.
        check(out_valid == 1'b0, "R9 valid in reset", out_valid, 0);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
        check(ch_ready == 9'b110110000, "R9 corner ready", ch_ready, 9'b110110000);
        fork
            driver();
            consumer();
        join
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R6 no extra output", out_valid, 0);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end
endmodule